// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks a fixed-size true-colour frame held in memory and turns a stream of pixel-advance strobes from the display timing into word read requests. Each returned 32-bit word is split into 8-bit red, green and blue channels, and frame-start and line-end markers travel with each pixel. Two write-only registers set it up: one holds the frame base address and one holds the enable and rotate bits.

Rows sit in memory on a padded stride of 1024 words, of which only the first 640 are fetched. The base address keeps only its upper 11 bits, so a frame starts on a 2 MiB boundary. Setting rotate reverses the whole scan, so the picture is shown turned through 180 degrees. Base and rotate changes are held back until the next frame begins, so a frame never mixes two settings.

Memory is external. The block expects the read word on `rd_data_i` in the cycle after the request. The default geometry is 640x480, and the visible size is set by parameters.

Top module: `fb_scan_gen`

## Requirements
- R1: After reset the display is disabled, base and rotate are zero, `rd_req_o` and `pix_vld_o` are low and all colour outputs are zero.
- R2: A write at byte offset 0 loads the base from `reg_wdata_i[31:21]`. A write at byte offset 4 loads control, with bit 0 as enable and bit 1 as rotate. A write at any other offset of `reg_addr_i` is ignored.
- R3: While enabled, every cycle with `pix_adv_i` high raises `rd_req_o` in that same cycle. While disabled, `rd_req_o` stays low.
- R4: Without rotation, visible pixel (x, y) is read from byte address {base[10:0], y[8:0], x[9:0], 2'b00}. The scan runs x ascending and then y ascending. Column fields of H_ACT or more are never requested.
- R5: With rotation active, visible pixel (x, y) is read from source column H_ACT-1-x and source row V_ACT-1-y.
- R6: Clearing enable stops requests, discards pixels still in flight and returns the scan to pixel (0,0). The first pixel after enable is set again is the first pixel of a new frame.
- R7: The base and rotate values used for a frame are the ones held when the frame's first pixel is requested. A write that lands in that same request cycle, or any later write, takes effect only at the next frame.
- R8: A pixel requested in cycle n appears with `pix_vld_o` high in cycle n+2. The block takes the word from `rd_data_i` in cycle n+1 and shows bits 23:16 as red, 15:8 as green and 7:0 as blue. Bits 31:24 are ignored.
- R9: `sof_o` is high with the pixel at (0,0) and `eol_o` is high with each pixel at x = H_ACT-1. Both are high only together with `pix_vld_o`.
- R10: While `pix_vld_o` is low, the red, green and blue outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte offset (0 base, 4 control) |
| reg_wdata_i | input | 32 | Register write data |
| pix_adv_i | input | 1 | Pixel-advance strobe from display timing |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Byte address of the requested word |
| rd_data_i | input | 32 | Read data, valid the cycle after the request |
| pix_vld_o | output | 1 | Pixel output valid |
| red_o | output | 8 | Red channel |
| green_o | output | 8 | Green channel |
| blue_o | output | 8 | Blue channel |
| sof_o | output | 1 | First pixel of a frame |
| eol_o | output | 1 | Last visible pixel of a row |

## Verification
A register write and the first-pixel request of a frame can fall in the same cycle. The shadow registers must then keep the old base and rotate for the frame that is starting and apply the new values only at the following frame. The bench forces this case directly: it re-enables the block and drives a base write together with the first `pix_adv_i`. Random writes during continuous advance strobes also hit frame starts. Its reference model takes the base and rotate it held in the cycle of the first-pixel request and checks every returned colour against a memory word computed from the address. Disable arriving while pixels are still in the two-stage pipeline is the second collision, and the bench checks that no stale pixel appears after it.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  localparam logic [2:0] REG_OFS_BASE = 3'd0;
  localparam logic [2:0] REG_OFS_CTRL = 3'd4;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_ROT_BIT = 1;
  localparam int CH_W    = 8;
  localparam int RED_LSB = 16;
  localparam int GRN_LSB = 8;
  localparam int BLU_LSB = 0;

  typedef struct packed {
    logic vld;
    logic sof;
    logic eol;
  } pix_tag_t;
endpackage

// File: rtl/fb_scan_regs.sv
module fb_scan_regs
  import fb_scan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              at_start_i,
  input  logic              frame_load_i,
  output logic              en_o,
  output logic [BASE_W-1:0] base_o,
  output logic              rot_o
);
  logic [BASE_W-1:0] base_q, base_act;
  logic              rot_q, rot_act, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      rot_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (we_i) begin
      if (addr_i == REG_OFS_BASE) begin
        base_q <= wdata_i[ADDR_W-1 -: BASE_W];
      end else if (addr_i == REG_OFS_CTRL) begin
        en_q  <= wdata_i[CTRL_EN_BIT];
        rot_q <= wdata_i[CTRL_ROT_BIT];
      end
    end
  end

  // active copy frozen at first-pixel request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_act <= '0;
      rot_act  <= 1'b0;
    end else if (frame_load_i) begin
      base_act <= base_q;
      rot_act  <= rot_q;
    end
  end

  assign en_o   = en_q;
  assign base_o = at_start_i ? base_q : base_act;
  assign rot_o  = at_start_i ? rot_q  : rot_act;

  assert_rot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_start_i && $past(!at_start_i) && $past(en_q) && en_q) |-> $stable(rot_o));
endmodule

// File: rtl/fb_scan_counter.sv
module fb_scan_counter #(
  parameter int H_ACT = 640,
  parameter int V_ACT = 480,
  parameter int XW    = $clog2(H_ACT),
  parameter int YW    = $clog2(V_ACT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          adv_i,
  output logic          req_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          at_start_o,
  output logic          sof_o,
  output logic          eol_o
);
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic          x_last, y_last;

  assign x_last = (x_q == XW'(H_ACT - 1));
  assign y_last = (y_q == YW'(V_ACT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (!en_i) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv_i) begin
      if (x_last) begin
        x_q <= '0;
        y_q <= y_last ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign req_o      = en_i & adv_i;
  assign x_o        = x_q;
  assign y_o        = y_q;
  assign at_start_o = (x_q == '0) && (y_q == '0);
  assign sof_o      = req_o & at_start_o;
  assign eol_o      = req_o & x_last;

  assert_x_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(x_q) < H_ACT);
  assert_y_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(y_q) < V_ACT);
  assert_row_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |=> (x_q == '0));
  assert_off_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> at_start_o);
endmodule

// File: rtl/fb_scan_addr.sv
module fb_scan_addr #(
  parameter int H_ACT      = 640,
  parameter int V_ACT      = 480,
  parameter int ADDR_W     = 32,
  parameter int BASE_W     = 11,
  parameter int STRIDE_LG2 = 10,
  parameter int XW         = $clog2(H_ACT),
  parameter int YW         = $clog2(V_ACT)
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic              rot_i,
  input  logic [XW-1:0]     x_i,
  input  logic [YW-1:0]     y_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int COL_W = STRIDE_LG2;
  localparam int ROW_W = ADDR_W - BASE_W - STRIDE_LG2 - 2;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_ACT - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_ACT - 1);

  logic [COL_W-1:0] col_fwd, col_src;
  logic [ROW_W-1:0] row_fwd, row_src;

  assign col_fwd = COL_W'(x_i);
  assign row_fwd = ROW_W'(y_i);

  always_comb begin
    if (rot_i) begin
      col_src = COL_LAST - col_fwd;
      row_src = ROW_LAST - row_fwd;
    end else begin
      col_src = col_fwd;
      row_src = row_fwd;
    end
  end

  assign addr_o = {base_i, row_src, col_src, 2'b00};
endmodule

// File: rtl/fb_scan_unpack.sv
module fb_scan_unpack
  import fb_scan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  pix_tag_t          tag_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              pix_vld_o,
  output logic [CH_W-1:0]   red_o,
  output logic [CH_W-1:0]   green_o,
  output logic [CH_W-1:0]   blue_o,
  output logic              sof_o,
  output logic              eol_o
);
  pix_tag_t tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_q <= '0;
    else         tag_q <= en_i ? tag_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_vld_o <= 1'b0;
      red_o     <= '0;
      green_o   <= '0;
      blue_o    <= '0;
      sof_o     <= 1'b0;
      eol_o     <= 1'b0;
    end else if (en_i && tag_q.vld) begin
      pix_vld_o <= 1'b1;
      red_o     <= rd_data_i[RED_LSB +: CH_W];
      green_o   <= rd_data_i[GRN_LSB +: CH_W];
      blue_o    <= rd_data_i[BLU_LSB +: CH_W];
      sof_o     <= tag_q.sof;
      eol_o     <= tag_q.eol;
    end else begin
      pix_vld_o <= 1'b0;
      red_o     <= '0;
      green_o   <= '0;
      blue_o    <= '0;
      sof_o     <= 1'b0;
      eol_o     <= 1'b0;
    end
  end

  assert_blank_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_o |-> (red_o == '0 && green_o == '0 && blue_o == '0));
  assert_marks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o || eol_o) |-> pix_vld_o);
  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> $past(tag_q.vld));
endmodule

// File: rtl/fb_scan_gen.sv
module fb_scan_gen
  import fb_scan_pkg::*;
#(
  parameter int H_ACT      = 640,
  parameter int V_ACT      = 480,
  parameter int ADDR_W     = 32,
  parameter int BASE_W     = 11,
  parameter int STRIDE_LG2 = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              pix_adv_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [ADDR_W-1:0] rd_data_i,
  output logic              pix_vld_o,
  output logic [7:0]        red_o,
  output logic [7:0]        green_o,
  output logic [7:0]        blue_o,
  output logic              sof_o,
  output logic              eol_o
);
  localparam int XW    = $clog2(H_ACT);
  localparam int YW    = $clog2(V_ACT);
  localparam int COL_W = STRIDE_LG2;

  logic              en, rot, at_start, req, sof_req, eol_req;
  logic [BASE_W-1:0] base;
  logic [XW-1:0]     x;
  logic [YW-1:0]     y;
  pix_tag_t          tag;

  fb_scan_regs #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .at_start_i   (at_start),
    .frame_load_i (sof_req),
    .en_o         (en),
    .base_o       (base),
    .rot_o        (rot)
  );

  fb_scan_counter #(.H_ACT(H_ACT), .V_ACT(V_ACT), .XW(XW), .YW(YW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .adv_i      (pix_adv_i),
    .req_o      (req),
    .x_o        (x),
    .y_o        (y),
    .at_start_o (at_start),
    .sof_o      (sof_req),
    .eol_o      (eol_req)
  );

  fb_scan_addr #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .ADDR_W(ADDR_W), .BASE_W(BASE_W),
    .STRIDE_LG2(STRIDE_LG2), .XW(XW), .YW(YW)
  ) u_addr (
    .base_i (base),
    .rot_i  (rot),
    .x_i    (x),
    .y_i    (y),
    .addr_o (rd_addr_o)
  );

  assign rd_req_o = req;
  assign tag      = '{vld: req, sof: sof_req, eol: eol_req};

  fb_scan_unpack #(.DATA_W(ADDR_W)) u_unpack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .tag_i     (tag),
    .rd_data_i (rd_data_i),
    .pix_vld_o (pix_vld_o),
    .red_o     (red_o),
    .green_o   (green_o),
    .blue_o    (blue_o),
    .sof_o     (sof_o),
    .eol_o     (eol_o)
  );

  assert_no_req_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !rd_req_o);
  assert_col_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (int'(rd_addr_o[COL_W+1:2]) < H_ACT));
  assert_word_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o[1:0] == 2'b00));
  assert_base_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !at_start && $past(rd_req_o))
      |-> (rd_addr_o[ADDR_W-1 -: BASE_W] == $past(rd_addr_o[ADDR_W-1 -: BASE_W])));
endmodule

// File: tb/fb_scan_gen_tb.sv
`timescale 1ns/1ps
module fb_scan_gen_tb;
  localparam int H = 12;
  localparam int V = 5;
  localparam int NPIX = H * V;

  logic        clk, rst_n;
  logic        reg_we, pix_adv;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, rd_data, rd_addr;
  logic        rd_req, pix_vld, sof, eol;
  logic [7:0]  red, green, blue;

  int checks = 0;
  int errors = 0;
  string tag = "R4";

  fb_scan_gen #(.H_ACT(H), .V_ACT(V)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .pix_adv_i(pix_adv), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .pix_vld_o(pix_vld), .red_o(red), .green_o(green), .blue_o(blue),
    .sof_o(sof), .eol_o(eol)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory content derived from the address; top byte is junk
  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    logic [10:0] b;
    logic [8:0]  r;
    logic [9:0]  c;
    b = a[31:21]; r = a[20:12]; c = a[11:2];
    return {a[9:2], c[9:1], c[0] ^ b[10], r, b[4:0] ^ b[9:5]};
  endfunction

  always @(posedge clk) rd_data <= rd_req ? mem_fn(rd_addr) : 32'hA5C3_96E1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // register model from requirement R2
  logic [10:0] m_base;
  logic        m_rot, m_en;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base <= '0; m_rot <= 1'b0; m_en <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == 3'd0) m_base <= reg_wdata[31:21];
      else if (reg_addr == 3'd4) begin
        m_en <= reg_wdata[0]; m_rot <= reg_wdata[1];
      end
    end
  end

  logic [10:0] hb0, hb1, hb2, e_base;
  logic        hr0, hr1, hr2, e_rot, m_en_d;
  int ex_x = 0, ex_y = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int sc, sr;
      logic [31:0] ea, ed;
      hb2 = hb1; hb1 = hb0; hb0 = m_base;
      hr2 = hr1; hr1 = hr0; hr0 = m_rot;
      chk(rd_req == (pix_adv && m_en), "R3 request", {31'b0, rd_req},
          {31'b0, pix_adv && m_en});
      if (rd_req)
        chk(rd_addr[1:0] == 2'b00 && int'(rd_addr[11:2]) < H, "R4 addr range",
            rd_addr, 32'h0);
      if (pix_vld) begin
        if (ex_x == 0 && ex_y == 0) begin
          e_base = hb2; e_rot = hr2;  // R7: values held at first-pixel request
        end
        sc = e_rot ? H - 1 - ex_x : ex_x;   // R5
        sr = e_rot ? V - 1 - ex_y : ex_y;
        ea = {e_base, 9'(sr), 10'(sc), 2'b00};
        ed = mem_fn(ea);
        chk({red, green, blue} == ed[23:0], {tag, "/R8 colour"},
            {8'h0, red, green, blue}, {8'h0, ed[23:0]});
        chk(sof == (ex_x == 0 && ex_y == 0), "R9 sof", {31'b0, sof},
            {31'b0, ex_x == 0 && ex_y == 0});
        chk(eol == (ex_x == H - 1), "R9 eol", {31'b0, eol}, {31'b0, ex_x == H - 1});
        if (ex_x == H - 1) begin
          ex_x = 0;
          ex_y = (ex_y == V - 1) ? 0 : ex_y + 1;
        end else ex_x++;
      end else begin
        chk({red, green, blue, sof, eol} == '0, "R10 idle outputs",
            {6'h0, red, green, blue, sof, eol}, 32'h0);
      end
      if (!m_en && !m_en_d)
        chk(!pix_vld && !rd_req, "R6 disabled quiet", {30'b0, pix_vld, rd_req}, 32'h0);
      if (!m_en) begin
        ex_x = 0; ex_y = 0;
      end
      m_en_d = m_en;
    end else begin
      hb0 = '0; hb1 = '0; hb2 = '0; hr0 = 0; hr1 = 0; hr2 = 0;
      m_en_d = 1'b0; ex_x = 0; ex_y = 0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic run(input int n, input int adv_pct, input int wr_pct, input bit rot_ok);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      pix_adv = (($urandom % 100) < adv_pct);
      reg_we  = 1'b0;
      if (($urandom % 100) < wr_pct) begin
        reg_we = 1'b1;
        case ($urandom % 4)
          0, 3: begin reg_addr = 3'd0; reg_wdata = $urandom; end
          1: begin reg_addr = 3'd4; reg_wdata = {30'b0, rot_ok & 1'($urandom), 1'b1}; end
          default: begin
            reg_addr = 3'($urandom % 4 == 0 ? 1 : ($urandom % 2 ? 2 : 6));
            reg_wdata = $urandom;
          end
        endcase
      end
    end
    @(posedge clk); #2;
    pix_adv = 1'b0; reg_we = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    errors++;
    $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; pix_adv = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!rd_req, "R1 no request in reset", {31'b0, rd_req}, 32'h0);
    chk(!pix_vld && {red, green, blue} == '0, "R1 outputs in reset",
        {7'h0, pix_vld, red, green, blue}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req, "R1 disabled after reset", {31'b0, rd_req}, 32'h0);
    @(posedge clk); #2; pix_adv = 1'b0;

    // R1/R4: enable with reset base, forward scan
    tag = "R4";
    wr(3'd4, 32'h1);
    run(NPIX + 10, 100, 0, 1'b0);
    run(NPIX, 60, 0, 1'b0);

    // R2: base write, ignored offsets (offset 6 carrying rotate must not apply)
    tag = "R2";
    wr(3'd0, 32'h1234_5678);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0000_0003);
    wr(3'd1, 32'h0000_0000);
    run(2 * NPIX, 70, 0, 1'b0);

    // R5: rotated scan
    tag = "R5";
    wr(3'd4, 32'h3);
    run(2 * NPIX, 80, 0, 1'b0);

    // R6: disable mid-frame, then restart
    tag = "R6";
    run(25, 100, 0, 1'b0);
    wr(3'd4, 32'h0);
    run(10, 100, 0, 1'b0);
    wr(3'd4, 32'h1);
    run(NPIX + 5, 100, 0, 1'b0);

    // R7: base write in the same cycle as the first-pixel request
    tag = "R7";
    wr(3'd4, 32'h0);
    wr(3'd0, 32'h0040_0000);
    wr(3'd4, 32'h3);
    @(posedge clk); #2;
    pix_adv = 1'b1; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'hFFE0_0000;
    @(posedge clk); #2;
    reg_we = 1'b0;
    run(2 * NPIX, 100, 0, 1'b1);
    run(8 * NPIX, 75, 5, 1'b1);
    run(4 * NPIX, 100, 8, 1'b1);

    wr(3'd4, 32'h0);
    run(6, 0, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule